// File: doc/BRIEF.md
# Dot Clock PLL Parameter Search

This block finds the programming values of a dot clock synthesizer for a requested pixel clock. The synthesizer output is a fixed 14318 kHz reference scaled by (n+8)/(m+2), using integer division, then halved when the post-divider bit k is set. After a start pulse the block walks every legal (k, m, n) combination, keeps the one whose frequency lies closest to the target, and packs the winner into a high and a low programming byte.

Two byte layouts are supported and chosen by a mode input sampled at start. The legacy layout spreads m across both bytes. The newer layout keeps n alone in the low byte. The chosen n, m, k and the frequency they reach are also reported directly. They stay valid from the done pulse until the next accepted start.

The quotient for each candidate is not divided from scratch. For each m a small restoring shift-subtract divider runs once to get the reference divided by (m+2). Each step in n then adds that quotient and remainder to a running sum, which costs one cycle per candidate.

Top module: `dotclk_pll_search`

## Requirements
- R1: After reset, done is 0 and n_sel, m_sel, k_sel, freq_khz, prog_hi and prog_lo are all 0.
- R2: freq_khz equals ((14318*(n_sel+8)) / (m_sel+2)) >> k_sel, with the division truncating.
- R3: The result always lies in range: n_sel is 0..121, m_sel is 0..31 and k_sel is 0 or 1.
- R4: The reported candidate has the smallest |f - target_khz| over all 7808 candidates. This includes the boundary targets 0 and 131071.
- R5: On equal error the earliest candidate wins. The search order is k = 1 then k = 0 on the outside, m rising from 0 inside that, and n rising from 0 innermost. A candidate replaces the best only when its error is strictly smaller.
- R6: With legacy_pack = 1 at start, prog_lo = {m[0], n[6:0]} and prog_hi = {3'b000, k, m[4:1]}. This is lo = n | (m<<7) and hi = (m>>1) | (k<<4).
- R7: With legacy_pack = 0 at start, prog_lo = {1'b0, n[6:0]} and prog_hi = {1'b0, k, 1'b0, m[4:0]}. This is lo = n and hi = m | (k<<6).
- R8: done is high for exactly one cycle after the last candidate has been evaluated. The results then hold until the next accepted start.
- R9: A start pulse that arrives while a search is running, or in the done cycle, is ignored. The running search keeps the target and mode it latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| target_khz | input | 17 | Requested pixel clock in kHz, sampled at an accepted start |
| legacy_pack | input | 1 | 1 selects the legacy byte layout, 0 the newer one; sampled at start |
| done | output | 1 | One-cycle pulse when the search completes |
| n_sel | output | 7 | Chosen numerator value n |
| m_sel | output | 5 | Chosen denominator value m |
| k_sel | output | 1 | Chosen post-divider bit k |
| freq_khz | output | 20 | Frequency reached by the chosen candidate |
| prog_hi | output | 8 | High programming byte |
| prog_lo | output | 8 | Low programming byte |

## Verification
A wrong running quotient or remainder corrupts every candidate frequency of the current m. It therefore shows at done as a freq_khz that no longer fits the formula for the reported n, m and k, or as a winner that misses the true minimum. A wrong comparison or a wrong search order shows at done as a different but equally close candidate. That is why the targets include values that several candidates reach exactly. A lost or stuck sequencer shows as a missing or stretched done pulse, about 9.2 thousand cycles after start.

// File: rtl/dotclk_pll_search.sv
module dotclk_pll_search #(
  parameter int REF_KHZ = 14318,
  parameter int N_COUNT = 122,
  parameter int M_COUNT = 32,
  parameter int N_OFF   = 8,
  parameter int M_OFF   = 2,
  parameter int TGT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target_khz,
  input  logic             legacy_pack,
  output logic             done,
  output logic [6:0]       n_sel,
  output logic [4:0]       m_sel,
  output logic             k_sel,
  output logic [19:0]      freq_khz,
  output logic [7:0]       prog_hi,
  output logic [7:0]       prog_lo
);
  localparam int N_W   = $clog2(N_COUNT);
  localparam int M_W   = $clog2(M_COUNT);
  localparam int D_W   = $clog2(M_COUNT + M_OFF);
  localparam int REF_W = $clog2(REF_KHZ + 1);
  localparam int Q_W   = $clog2(REF_KHZ * (N_COUNT - 1 + N_OFF) / M_OFF + 1);
  localparam int ERR_W = ((Q_W > TGT_W) ? Q_W : TGT_W) + 1;
  localparam int C_W   = $clog2((REF_W > N_OFF) ? REF_W : N_OFF) + 1;

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_DIV = 3'd1, S_PRE = 3'd2,
                            S_EVAL = 3'd3, S_DONE = 3'd4} state_t;
  state_t state;

  logic             k_q;
  logic [M_W-1:0]   m_q;
  logic [N_W-1:0]   n_q;
  logic [C_W-1:0]   cnt;
  logic [REF_W-1:0] div_dq;
  logic [D_W-1:0]   div_rem;
  logic [Q_W-1:0]   acc_q;
  logic [D_W-1:0]   acc_r;
  logic [TGT_W-1:0] tgt_q;
  logic             legacy_q;
  logic [ERR_W-1:0] best_err;
  logic [N_W-1:0]   best_n;
  logic [M_W-1:0]   best_m;
  logic             best_k;
  logic [Q_W-1:0]   best_f;

  logic [D_W-1:0] divisor;
  logic [D_W:0]   trial, sum_r;
  logic           div_ge, wrap;
  logic [D_W-1:0] r_nxt;
  logic [Q_W-1:0] q_nxt, cand_f;
  logic [ERR_W-1:0] cand_e, tgt_e, err;

  assign divisor = D_W'(m_q) + D_W'(M_OFF);
  assign trial   = {div_rem, div_dq[REF_W-1]};
  assign div_ge  = trial >= {1'b0, divisor};
  assign sum_r   = {1'b0, acc_r} + {1'b0, div_rem};
  assign wrap    = sum_r >= {1'b0, divisor};
  assign r_nxt   = wrap ? D_W'(sum_r - {1'b0, divisor}) : D_W'(sum_r);
  assign q_nxt   = acc_q + Q_W'(div_dq) + Q_W'(wrap);
  assign cand_f  = acc_q >> k_q;
  assign cand_e  = ERR_W'(cand_f);
  assign tgt_e   = ERR_W'(tgt_q);
  assign err     = (cand_e >= tgt_e) ? cand_e - tgt_e : tgt_e - cand_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      k_q      <= 1'b0;
      m_q      <= '0;
      n_q      <= '0;
      cnt      <= '0;
      div_dq   <= '0;
      div_rem  <= '0;
      acc_q    <= '0;
      acc_r    <= '0;
      tgt_q    <= '0;
      legacy_q <= 1'b0;
      best_err <= '0;
      best_n   <= '0;
      best_m   <= '0;
      best_k   <= 1'b0;
      best_f   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          tgt_q    <= target_khz;
          legacy_q <= legacy_pack;
          best_err <= '1;
          k_q      <= 1'b1;
          m_q      <= '0;
          div_dq   <= REF_W'(REF_KHZ);
          div_rem  <= '0;
          cnt      <= '0;
          state    <= S_DIV;
        end
        S_DIV: begin
          div_dq  <= {div_dq[REF_W-2:0], div_ge};
          div_rem <= div_ge ? D_W'(trial - {1'b0, divisor}) : D_W'(trial);
          cnt     <= cnt + 1'b1;
          if (cnt == C_W'(REF_W - 1)) begin
            cnt   <= '0;
            acc_q <= '0;
            acc_r <= '0;
            state <= S_PRE;
          end
        end
        S_PRE: begin
          acc_q <= q_nxt;
          acc_r <= r_nxt;
          cnt   <= cnt + 1'b1;
          if (cnt == C_W'(N_OFF - 1)) begin
            n_q   <= '0;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (err < best_err) begin
            best_err <= err;
            best_n   <= n_q;
            best_m   <= m_q;
            best_k   <= k_q;
            best_f   <= cand_f;
          end
          if (n_q == N_W'(N_COUNT - 1)) begin
            div_dq  <= REF_W'(REF_KHZ);
            div_rem <= '0;
            cnt     <= '0;
            if (m_q != M_W'(M_COUNT - 1)) begin
              m_q   <= m_q + 1'b1;
              state <= S_DIV;
            end else if (k_q) begin
              k_q   <= 1'b0;
              m_q   <= '0;
              state <= S_DIV;
            end else begin
              state <= S_DONE;
            end
          end else begin
            n_q   <= n_q + 1'b1;
            acc_q <= q_nxt;
            acc_r <= r_nxt;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done     = (state == S_DONE);
  assign n_sel    = 7'(best_n);
  assign m_sel    = 5'(best_m);
  assign k_sel    = best_k;
  assign freq_khz = 20'(best_f);
  assign prog_lo  = legacy_q ? {m_sel[0], n_sel} : {1'b0, n_sel};
  assign prog_hi  = legacy_q ? {3'b000, k_sel, m_sel[4:1]}
                             : {1'b0, k_sel, 1'b0, m_sel};
endmodule

module dotclk_pll_search_chk #(
  parameter int D_W   = 6,
  parameter int ERR_W = 21,
  parameter int TGT_W = 17,
  parameter int N_MAX = 121
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic [2:0]       st,
  input logic [D_W-1:0]   acc_r,
  input logic [D_W-1:0]   divisor,
  input logic [ERR_W-1:0] best_err,
  input logic [TGT_W-1:0] tgt_q,
  input logic [6:0]       n_sel
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0) |=> $stable(tgt_q)); // R9
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |-> (acc_r < divisor)); // R2
  AST_ERR_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) == 3'd3) |-> (best_err <= $past(best_err))); // R4
  AST_N_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(n_sel) <= N_MAX)); // R3
endmodule

bind dotclk_pll_search dotclk_pll_search_chk #(
  .D_W(D_W), .ERR_W(ERR_W), .TGT_W(TGT_W), .N_MAX(N_COUNT - 1)
) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .st(state), .acc_r(acc_r),
  .divisor(divisor), .best_err(best_err), .tgt_q(tgt_q), .n_sel(n_sel)
);

// File: tb/dotclk_pll_search_tb_top.sv
`timescale 1ns/1ps
module dotclk_pll_search_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [16:0] target_khz = '0;
  logic legacy_pack = 1'b0;
  logic done, k_sel;
  logic [6:0] n_sel;
  logic [4:0] m_sel;
  logic [19:0] freq_khz;
  logic [7:0] prog_hi, prog_lo;

  int tests = 0;
  int fails = 0;
  int en, em, ek, ef;

  always #2.5 clk = ~clk;

  dotclk_pll_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .legacy_pack(legacy_pack), .done(done), .n_sel(n_sel), .m_sel(m_sel),
    .k_sel(k_sel), .freq_khz(freq_khz), .prog_hi(prog_hi), .prog_lo(prog_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int tgt);
    longint best = 64'h7fffffffffffffff;
    for (int k = 1; k >= 0; k--)
      for (int m = 0; m < 32; m++)
        for (int n = 0; n < 122; n++) begin
          longint f = ((14318 * (n + 8)) / (m + 2)) >> k;
          longint e = (f > tgt) ? f - tgt : tgt - f;
          if (e < best) begin
            best = e; en = n; em = m; ek = k; ef = int'(f);
          end
        end
  endtask

  task automatic pulse_start(input int tgt, input bit legacy);
    @(negedge clk);
    start = 1'b1; target_khz = 17'(tgt); legacy_pack = legacy;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_result(input int tgt, input bit legacy, input string tag);
    int ehi, elo;
    model(tgt);
    chk({tag, " R4 n"}, int'(n_sel), en);
    chk({tag, " R5 m"}, int'(m_sel), em);
    chk({tag, " R5 k"}, int'(k_sel), ek);
    chk({tag, " R2 freq formula"}, int'(freq_khz),
        ((14318 * (int'(n_sel) + 8)) / (int'(m_sel) + 2)) >> k_sel);
    chk({tag, " R4 freq"}, int'(freq_khz), ef);
    chk({tag, " R3 n range"}, int'(n_sel <= 7'd121), 1);
    if (legacy) begin
      elo = (en | (em << 7)) & 8'hff;
      ehi = (em >> 1) | (ek << 4);
      chk({tag, " R6 lo"}, int'(prog_lo), elo);
      chk({tag, " R6 hi"}, int'(prog_hi), ehi);
    end else begin
      elo = en;
      ehi = em | (ek << 6);
      chk({tag, " R7 lo"}, int'(prog_lo), elo);
      chk({tag, " R7 hi"}, int'(prog_hi), ehi);
    end
  endtask

  task automatic run(input int tgt, input bit legacy, input string tag);
    bit ok;
    logic [7:0] hi0, lo0;
    pulse_start(tgt, legacy);
    wait_done(ok);
    chk({tag, " R8 done seen"}, int'(ok), 1);
    check_result(tgt, legacy, tag);
    hi0 = prog_hi; lo0 = prog_lo;
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, int'(done), 0);
    repeat (5) @(negedge clk);
    chk({tag, " R8 hold hi"}, int'(prog_hi), int'(hi0));
    chk({tag, " R8 hold lo"}, int'(prog_lo), int'(lo0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 n", int'(n_sel), 0);
    chk("R1 m", int'(m_sel), 0);
    chk("R1 k", int'(k_sel), 0);
    chk("R1 freq", int'(freq_khz), 0);
    chk("R1 hi", int'(prog_hi), 0);
    chk("R1 lo", int'(prog_lo), 0);

    run(25175, 1'b1, "t25175");
    run(40000, 1'b0, "t40000");
    run(65000, 1'b1, "t65000");
    run(108000, 1'b0, "t108000");
    run(0, 1'b1, "tzero");          // R4 lower boundary
    run(131071, 1'b0, "tmax");      // R4 upper boundary
    run(14318, 1'b1, "tref");       // R5 many exact hits

    // R9 start while busy is ignored
    pulse_start(31500, 1'b1);
    repeat (200) @(negedge clk);
    start = 1'b1; target_khz = 17'd90000; legacy_pack = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk("R9 done seen", int'(ok), 1);
    check_result(31500, 1'b1, "R9 busy");
    // R9 start in the done cycle is ignored
    start = 1'b1; target_khz = 17'd50000; legacy_pack = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check_result(31500, 1'b1, "R9 donecycle");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule